// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the host-facing register file of a classic 16550-style serial controller. A host reaches it over a byte-wide bus with a 3-bit register offset. It holds the line format, modem handshake outputs, interrupt enables, FIFO setup, a scratch byte and the 16-bit baud divisor. The divisor bytes share offsets 0 and 1 with the data port and the interrupt-enable register. Bit 7 of the line control register picks which pair the host sees. Offset 2 reads the interrupt identification byte, and a write to offset 2 goes to the FIFO setup.

The serializer, the deserializer and the FIFO storage sit outside this block, and only their flags and bytes come in. The bank turns host accesses to offset 0 into push and pop strobes for those FIFOs. It folds the FIFO flags and the receive error pulses into a line status byte. It tracks edges on the modem inputs and ranks the pending interrupt causes. It also produces a baud tick at sixteen times the bit rate, which the serializer and deserializer share.

Top module: `uart_regbank`

## Requirements
- R1: After a synchronous reset the divisor is 0x0001 and every other stored register (line control, interrupt enable, FIFO setup, modem control, scratch, sticky error and modem-delta bits) is zero.
- R2: With line control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. Neither access strobes the FIFOs. With bit 7 clear, offset 1 is the interrupt enable register. Its low 4 bits are stored and its upper bits read as zero.
- R3: Line control (offset 3) and scratch (offset 7) read back every written byte. The line control fields drive the outputs: bits 1:0 word length, bit 2 stop-bit count, bit 3 parity enable, bit 4 even parity, bit 5 sticky parity, bit 6 forced break.
- R4: For a nonzero divisor D, `baud_tick` is a one-cycle pulse every D clocks. A divisor of zero stops the tick.
- R5: A write to offset 2 sets FIFO enable from bit 0 and the receive trigger select from bits 7:6. Bit 1 and bit 2 give a one-cycle pulse on `rx_clr` and `tx_clr` in the cycle after the write, and the pulse is not stored. Identification bits 7:6 read 11 while the FIFOs are enabled and 00 otherwise.
- R6: Line status (offset 5) reads bit 0 data ready (receive FIFO not empty), bit 5 transmit FIFO empty, and bit 6 transmit FIFO empty with the serializer idle. Bit 7 reads zero.
- R7: Line status bit 4 break, bit 3 framing, bit 2 parity and bit 1 overrun are sticky. A read of offset 5 clears them, but an error pulse in the same cycle as that read stays set.
- R8: Modem status (offset 6) shows carrier detect, ring, data-set-ready and clear-to-send on bits 7..4. Bits 3..0 flag a change on each of those inputs since the last read of offset 6. The read clears them, but a change in the same cycle stays set.
- R9: Identification bits 3:0 encode the highest-priority enabled pending cause: line error 0x6 (enable bit 2), received data 0x4 (enable bit 0), transmit FIFO empty 0x2 (enable bit 1), modem change 0x0 (enable bit 3). With nothing pending they read 0x1.
- R10: The received-data cause is pending when the receive FIFO is not empty with FIFOs off. With FIFOs on it is pending when `rx_level` is at least the trigger depth 1, 4, 8 or 14 for select 0..3.
- R11: Modem control (offset 4) stores 4 bits that read back with the upper bits zero, and drive DTR (bit 0), RTS (bit 1), OUT1 (bit 2) and OUT2 (bit 3). `irq` is high exactly when OUT2 is set and a cause is pending.
- R12: With line control bit 7 clear, a read of offset 0 returns `rx_data` and pulses `rx_pop`. A write of offset 0 pulses `tx_push` with `tx_data` equal to the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 8 | Byte pushed to the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_idle | input | 1 | Serializer has no bit in flight |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_brk | input | 1 | Break detected pulse |
| rx_ferr | input | 1 | Framing error pulse |
| rx_perr | input | 1 | Parity error pulse |
| rx_oerr | input | 1 | Overrun pulse |
| fifo_en | output | 1 | FIFOs enabled |
| rx_trig | output | 2 | Receive trigger select |
| rx_clr | output | 1 | Receive FIFO clear pulse |
| tx_clr | output | 1 | Transmit FIFO clear pulse |
| word_len | output | 2 | Word length code |
| stop2 | output | 1 | Extra stop bit |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity |
| par_stick | output | 1 | Sticky parity |
| send_break | output | 1 | Force line to break |
| baud_tick | output | 1 | Tick at sixteen times the bit rate |
| cts | input | 1 | Clear to send |
| dsr | input | 1 | Data set ready |
| ri | input | 1 | Ring indicate |
| dcd | input | 1 | Carrier detect |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out1 | output | 1 | Auxiliary output 1 |
| out2 | output | 1 | Auxiliary output 2, gates irq |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default FIFO_DEPTH of 16, so `rx_level` is five bits wide and every level from 0 to 16 can be swept against each of the four trigger depths. The small divisors 0 to 8 bring the tick spacing and the stopped tick within a few dozen cycles. The byte-wide registers are short enough that every scratch and line-control value is written and read back. All 256 combinations of the four interrupt enables and the four pending causes are ranked against an expected code computed in the bench.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int NIB_W  = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_IDFC  = 3'd2,
        OFS_LINE  = 3'd3,
        OFS_MODEM = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SCR   = 3'd7
    } ofs_e;

    // bit 7 down to bit 0 of the line control byte
    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop2;
        logic [1:0] wlen;
    } line_ctl_t;

    typedef struct packed {
        logic wr_data;
        logic rd_data;
        logic wr_ien;
        logic wr_dll;
        logic wr_dlh;
        logic wr_fcr;
        logic wr_lcr;
        logic wr_mcr;
        logic wr_scr;
        logic rd_lsr;
        logic rd_msr;
    } strobe_t;

    typedef enum logic [2:0] {
        CAUSE_MODEM = 3'b000,
        CAUSE_TX    = 3'b001,
        CAUSE_RX    = 3'b010,
        CAUSE_LINE  = 3'b011
    } cause_e;

    function automatic logic [3:0] trig_depth(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd1;
            2'd1:    return 4'd4;
            2'd2:    return 4'd8;
            default: return 4'd14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             wr,
    input  logic             rd,
    input  logic             dlab,
    output strobe_t          stb
);
    ofs_e ofs;
    assign ofs = ofs_e'(addr);

    always_comb begin
        stb = '0;
        unique case (ofs)
            OFS_DATA: begin
                stb.wr_dll  = wr &  dlab;
                stb.wr_data = wr & ~dlab;
                stb.rd_data = rd & ~dlab;
            end
            OFS_IEN: begin
                stb.wr_dlh = wr &  dlab;
                stb.wr_ien = wr & ~dlab;
            end
            OFS_IDFC:  stb.wr_fcr = wr;
            OFS_LINE:  stb.wr_lcr = wr;
            OFS_MODEM: stb.wr_mcr = wr;
            OFS_LSTAT: stb.rd_lsr = rd;
            OFS_MSTAT: stb.rd_msr = rd;
            OFS_SCR:   stb.wr_scr = wr;
        endcase
    end
endmodule

// File: rtl/uart_rb_baud.sv
module uart_rb_baud #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             stopped;
    logic             wrap;

    assign stopped = (divisor == '0);
    assign wrap    = (cnt_q >= divisor - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (restart || stopped) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rb_modem.sv
module uart_rb_modem
    import uart_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] pins,
    input  logic             rd_clr,
    output logic [BYTE_W-1:0] status
);
    logic [NIB_W-1:0] level_q;
    logic [NIB_W-1:0] delta_q;
    logic [NIB_W-1:0] change;

    assign change = pins ^ level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            delta_q <= '0;
        end else begin
            level_q <= pins;
            delta_q <= (rd_clr ? '0 : delta_q) | change;
        end
    end

    assign status = {level_q, delta_q};
endmodule

// File: rtl/uart_rb_intr.sv
module uart_rb_intr
    import uart_rb_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [NIB_W-1:0]  ien,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_ready,
    input  logic              thr_empty,
    input  logic [NIB_W-1:0]  line_err,
    input  logic [NIB_W-1:0]  modem_delta,
    input  logic              gate,
    output logic [BYTE_W-1:0] ident,
    output logic              irq
);
    logic [LVL_W-1:0] thresh;
    logic             rx_cond;
    logic             p_line, p_rx, p_tx, p_modem, any;
    cause_e           cause;

    assign thresh  = LVL_W'(trig_depth(trig_sel));
    assign rx_cond = fifo_en ? (rx_level >= thresh) : rx_ready;

    assign p_line  = ien[2] & (|line_err);
    assign p_rx    = ien[0] & rx_cond;
    assign p_tx    = ien[1] & thr_empty;
    assign p_modem = ien[3] & (|modem_delta);
    assign any     = p_line | p_rx | p_tx | p_modem;

    always_comb begin
        if (p_line)      cause = CAUSE_LINE;
        else if (p_rx)   cause = CAUSE_RX;
        else if (p_tx)   cause = CAUSE_TX;
        else             cause = CAUSE_MODEM;
    end

    assign ident = {{2{fifo_en}}, 2'b00, cause, ~any};
    assign irq   = gate & any;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_empty,
    input  logic              tx_idle,
    output logic              rx_pop,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_empty,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_brk,
    input  logic              rx_ferr,
    input  logic              rx_perr,
    input  logic              rx_oerr,
    output logic              fifo_en,
    output logic [1:0]        rx_trig,
    output logic              rx_clr,
    output logic              tx_clr,
    output logic [1:0]        word_len,
    output logic              stop2,
    output logic              par_en,
    output logic              par_even,
    output logic              par_stick,
    output logic              send_break,
    output logic              baud_tick,
    input  logic              cts,
    input  logic              dsr,
    input  logic              ri,
    input  logic              dcd,
    output logic              dtr,
    output logic              rts,
    output logic              out1,
    output logic              out2,
    output logic              irq
);
    strobe_t            stb;
    line_ctl_t          lcr_q;
    logic [NIB_W-1:0]   ien_q;
    logic [NIB_W-1:0]   mcr_q;
    logic [BYTE_W-1:0]  scr_q;
    logic [DIV_W-1:0]   div_q;
    logic               fen_q;
    logic [1:0]         trig_q;
    logic               rxclr_q, txclr_q;
    logic [NIB_W-1:0]   lerr_q;
    logic [NIB_W-1:0]   err_in;
    logic [BYTE_W-1:0]  lsr;
    logic [BYTE_W-1:0]  msr;
    logic [BYTE_W-1:0]  iir;

    uart_rb_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .dlab (lcr_q.dlab),
        .stb  (stb)
    );

    // configuration and control state
    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q   <= '0;
            ien_q   <= '0;
            mcr_q   <= '0;
            scr_q   <= '0;
            div_q   <= DIV_W'(1);
            fen_q   <= 1'b0;
            trig_q  <= '0;
            rxclr_q <= 1'b0;
            txclr_q <= 1'b0;
        end else begin
            if (stb.wr_lcr) lcr_q <= line_ctl_t'(bus_wdata);
            if (stb.wr_ien) ien_q <= bus_wdata[NIB_W-1:0];
            if (stb.wr_mcr) mcr_q <= bus_wdata[NIB_W-1:0];
            if (stb.wr_scr) scr_q <= bus_wdata;
            if (stb.wr_dll) div_q[BYTE_W-1:0]     <= bus_wdata;
            if (stb.wr_dlh) div_q[DIV_W-1:BYTE_W] <= bus_wdata;
            if (stb.wr_fcr) begin
                fen_q  <= bus_wdata[0];
                trig_q <= bus_wdata[7:6];
            end
            rxclr_q <= stb.wr_fcr & bus_wdata[1];
            txclr_q <= stb.wr_fcr & bus_wdata[2];
        end
    end

    // sticky receive errors: {break, framing, parity, overrun}
    assign err_in = {rx_brk, rx_ferr, rx_perr, rx_oerr};

    always_ff @(posedge clk) begin
        if (rst) lerr_q <= '0;
        else     lerr_q <= (stb.rd_lsr ? '0 : lerr_q) | err_in;
    end

    assign lsr = {1'b0, tx_empty & tx_idle, tx_empty, lerr_q, ~rx_empty};

    uart_rb_modem u_modem (
        .clk    (clk),
        .rst    (rst),
        .pins   ({dcd, ri, dsr, cts}),
        .rd_clr (stb.rd_msr),
        .status (msr)
    );

    uart_rb_intr #(.LVL_W(LVL_W)) u_intr (
        .ien         (ien_q),
        .fifo_en     (fen_q),
        .trig_sel    (trig_q),
        .rx_level    (rx_level),
        .rx_ready    (~rx_empty),
        .thr_empty   (tx_empty),
        .line_err    (lerr_q),
        .modem_delta (msr[NIB_W-1:0]),
        .gate        (mcr_q[3]),
        .ident       (iir),
        .irq         (irq)
    );

    uart_rb_baud #(.CNT_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .divisor (div_q),
        .restart (stb.wr_dll | stb.wr_dlh),
        .tick    (baud_tick)
    );

    // read mux
    always_comb begin
        unique case (ofs_e'(bus_addr))
            OFS_DATA:  bus_rdata = lcr_q.dlab ? div_q[BYTE_W-1:0] : rx_data;
            OFS_IEN:   bus_rdata = lcr_q.dlab ? div_q[DIV_W-1:BYTE_W]
                                              : {{(BYTE_W-NIB_W){1'b0}}, ien_q};
            OFS_IDFC:  bus_rdata = iir;
            OFS_LINE:  bus_rdata = lcr_q;
            OFS_MODEM: bus_rdata = {{(BYTE_W-NIB_W){1'b0}}, mcr_q};
            OFS_LSTAT: bus_rdata = lsr;
            OFS_MSTAT: bus_rdata = msr;
            OFS_SCR:   bus_rdata = scr_q;
        endcase
    end

    assign tx_push    = stb.wr_data;
    assign tx_data    = bus_wdata;
    assign rx_pop     = stb.rd_data;
    assign fifo_en    = fen_q;
    assign rx_trig    = trig_q;
    assign rx_clr     = rxclr_q;
    assign tx_clr     = txclr_q;
    assign word_len   = lcr_q.wlen;
    assign stop2      = lcr_q.stop2;
    assign par_en     = lcr_q.par_en;
    assign par_even   = lcr_q.even;
    assign par_stick  = lcr_q.stick;
    assign send_break = lcr_q.brk;
    assign dtr        = mcr_q[0];
    assign rts        = mcr_q[1];
    assign out1       = mcr_q[2];
    assign out2       = mcr_q[3];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic        dlab,
    input logic [15:0] div_q,
    input logic [3:0]  lerr_q,
    input logic [3:0]  err_in,
    input logic        baud_tick,
    input logic        rx_pop,
    input logic        rx_clr,
    input logic        irq,
    input logic        out2
);
    // R4
    baud_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (div_q == 16'd0) |=> !baud_tick);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> out2);

    // R12
    pop_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (bus_rd && bus_addr == 3'd0 && !dlab));

    // R5
    rxclr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_clr |-> $past(bus_wr && bus_addr == 3'd2 && bus_wdata[1]));

    // R7
    lsr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd5 && err_in == 4'd0) |=> (lerr_q == 4'd0));

    // R2
    dll_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dlab && bus_addr == 3'd0) |=> (div_q[7:0] == $past(bus_wdata)));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .dlab      (lcr_q.dlab),
    .div_q     (div_q),
    .lerr_q    (lerr_q),
    .err_in    (err_in),
    .baud_tick (baud_tick),
    .rx_pop    (rx_pop),
    .rx_clr    (rx_clr),
    .irq       (irq),
    .out2      (out2)
);

// File: tb/tb_uart_regbank.sv
module tb_uart_regbank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_push, rx_pop;
    logic [7:0] tx_data;
    logic       tx_empty = 1'b1, tx_idle = 1'b1, rx_empty = 1'b1;
    logic [7:0] rx_data = '0;
    logic [4:0] rx_level = '0;
    logic [3:0] errv = '0;
    logic       fifo_en, rx_clr, tx_clr, stop2, par_en, par_even, par_stick, send_break;
    logic [1:0] rx_trig, word_len;
    logic       baud_tick;
    logic [3:0] mpins = '0;
    logic       dtr, rts, out1, out2, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_regbank dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_push(tx_push), .tx_data(tx_data),
        .tx_empty(tx_empty), .tx_idle(tx_idle), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .rx_level(rx_level), .rx_brk(errv[3]), .rx_ferr(errv[2]),
        .rx_perr(errv[1]), .rx_oerr(errv[0]), .fifo_en(fifo_en), .rx_trig(rx_trig),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .word_len(word_len), .stop2(stop2),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .send_break(send_break), .baud_tick(baud_tick), .cts(mpins[0]), .dsr(mpins[1]),
        .ri(mpins[2]), .dcd(mpins[3]), .dtr(dtr), .rts(rts), .out1(out1), .out2(out2),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    logic [7:0] rdv;
    logic       popv;
    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        rdv = bus_rdata; popv = rx_pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] d);
        wr(3'd3, 8'h80);
        wr(3'd0, d[7:0]);
        wr(3'd1, d[15:8]);
        wr(3'd3, 8'h00);
    endtask

    function automatic logic [7:0] exp_iir(input logic [3:0] ie, input logic [3:0] c,
                                           input logic fe);
        logic [7:0] v;
        if (ie[2] & c[0])      v = 8'h06;
        else if (ie[0] & c[1]) v = 8'h04;
        else if (ie[1] & c[2]) v = 8'h02;
        else if (ie[3] & c[3]) v = 8'h00;
        else                   v = 8'h01;
        return fe ? (v | 8'hC0) : v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int gap;
        logic [3:0] prevp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(3'd1); chk("R1 ien", rdv, 8'h00);
        rd(3'd2); chk("R1 iir", rdv, 8'h01);
        rd(3'd3); chk("R1 lcr", rdv, 8'h00);
        rd(3'd4); chk("R1 mcr", rdv, 8'h00);
        rd(3'd5); chk("R1 lsr", rdv, 8'h60);
        rd(3'd6); chk("R1 msr", rdv, 8'h00);
        rd(3'd7); chk("R1 scr", rdv, 8'h00);
        chk("R1 outs", {fifo_en, rx_trig, dtr, rts, out1, out2, irq, send_break}, 0);
        wr(3'd3, 8'h80);
        rd(3'd0); chk("R1 dll", rdv, 8'h01);
        rd(3'd1); chk("R1 dlh", rdv, 8'h00);

        // R2 overlay
        wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        rx_data = 8'h5A; rx_empty = 1'b0;
        rd(3'd0); chk("R2 dll", rdv, 8'h34); chk("R2 no pop", popv, 0);
        rd(3'd1); chk("R2 dlh", rdv, 8'h12);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hFF);
        rd(3'd1); chk("R2 ien", rdv, 8'h0F);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h80);
        rd(3'd1); chk("R2 dlh kept", rdv, 8'h12);
        wr(3'd3, 8'h00);

        // R12 data path
        rd(3'd0); chk("R12 rx data", rdv, 8'h5A); chk("R12 pop", popv, 1);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'hC3; bus_wr = 1'b1;
        #1 chk("R12 push", {tx_push, tx_data}, {1'b1, 8'hC3});
        @(negedge clk); bus_wr = 1'b0;
        #1 chk("R12 push idle", tx_push, 0);
        rx_empty = 1'b1;

        // R3 scratch and line control sweeps
        for (int v = 0; v < 256; v++) begin
            wr(3'd7, 8'(v));
            rd(3'd7); chk("R3 scr", rdv, v);
        end
        for (int v = 0; v < 256; v++) begin
            wr(3'd3, 8'(v));
            rd(3'd3); chk("R3 lcr", rdv, v);
            chk("R3 lcr fields", {send_break, par_stick, par_even, par_en, stop2, word_len},
                v & 8'h7F);
        end
        wr(3'd3, 8'h00);

        // R11 modem control
        for (int v = 0; v < 16; v++) begin
            wr(3'd4, 8'(v) | 8'hF0);
            rd(3'd4); chk("R11 mcr", rdv, v);
            chk("R11 pins", {out2, out1, rts, dtr}, v);
        end

        // R4 baud tick spacing
        for (int d = 1; d <= 8; d++) begin
            set_div(16'(d));
            gap = 0;
            while (!baud_tick && gap < 100) begin @(negedge clk); gap++; end
            gap = 0;
            do begin @(negedge clk); gap++; end while (!baud_tick && gap < 100);
            chk("R4 tick period", gap, d);
        end
        set_div(16'd0);
        gap = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (baud_tick) gap++; end
        chk("R4 zero stops", gap, 0);
        set_div(16'd1);

        // R5 FIFO setup
        wr(3'd2, 8'h07);
        chk("R5 clr pulse", {rx_clr, tx_clr}, 2'b11);
        chk("R5 enable", fifo_en, 1);
        @(negedge clk);
        chk("R5 clr one cycle", {rx_clr, tx_clr}, 2'b00);
        wr(3'd2, 8'h03);
        chk("R5 rx clr only", {rx_clr, tx_clr}, 2'b10);
        wr(3'd2, 8'h05);
        chk("R5 tx clr only", {rx_clr, tx_clr}, 2'b01);
        wr(3'd4, 8'h08);
        wr(3'd1, 8'h01);
        tx_empty = 1'b0;

        // R10 trigger levels in FIFO mode
        for (int s = 0; s < 4; s++) begin
            int thr;
            thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            wr(3'd2, 8'(s << 6) | 8'h01);
            chk("R5 trig sel", rx_trig, s);
            for (int l = 0; l <= 16; l++) begin
                rx_level = 5'(l);
                rd(3'd2);
                chk("R10 fifo rx cond", rdv, (l >= thr) ? 8'hC4 : 8'hC1);
            end
        end
        rx_level = '0;
        wr(3'd2, 8'h00);
        rd(3'd2); chk("R5 id top bits off", rdv[7:6], 0);

        // R6 line status composition
        for (int k = 0; k < 8; k++) begin
            rx_empty = k[0]; tx_empty = k[1]; tx_idle = k[2];
            rd(3'd5);
            chk("R6 lsr", rdv, {1'b0, k[1] & k[2], k[1], 4'b0, ~k[0]});
        end
        rx_empty = 1'b1; tx_empty = 1'b1; tx_idle = 1'b1;

        // R7 sticky errors
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); errv = 4'(1 << b);
            @(negedge clk); errv = '0;
            repeat (2) @(negedge clk);
            rd(3'd5); chk("R7 sticky", rdv, 8'h60 | 8'(2 << b));
            rd(3'd5); chk("R7 cleared", rdv, 8'h60);
        end
        @(negedge clk);
        bus_addr = 3'd5; bus_rd = 1'b1; errv = 4'b0001;
        @(negedge clk);
        bus_rd = 1'b0; errv = '0;
        rd(3'd5); chk("R7 set wins", rdv, 8'h62);
        rd(3'd5);

        // R8 modem status
        prevp = 4'h0;
        for (int p = 1; p < 16; p++) begin
            mpins = 4'(p);
            repeat (2) @(negedge clk);
            rd(3'd6); chk("R8 msr delta", rdv, {4'(p), 4'(p) ^ prevp});
            rd(3'd6); chk("R8 msr clear", rdv, {4'(p), 4'h0});
            prevp = 4'(p);
        end
        mpins = '0;
        repeat (2) @(negedge clk);
        rd(3'd6);

        // R9 priority sweep and R11 irq gate, FIFOs off
        wr(3'd4, 8'h08);
        for (int ie = 0; ie < 16; ie++) begin
            wr(3'd1, 8'(ie));
            for (int c = 0; c < 16; c++) begin
                rx_empty = ~c[1]; tx_empty = c[2];
                if (c[0]) begin @(negedge clk); errv = 4'b0100; @(negedge clk); errv = '0; end
                if (c[3]) begin @(negedge clk); mpins[0] = ~mpins[0]; end
                repeat (2) @(negedge clk);
                rd(3'd2);
                chk("R9 iir", rdv, exp_iir(4'(ie), 4'(c), 1'b0));
                chk("R11 irq", irq, ~exp_iir(4'(ie), 4'(c), 1'b0) & 8'h01);
                rd(3'd5); rd(3'd6);
            end
        end
        wr(3'd1, 8'h01);
        rx_empty = 1'b0; tx_empty = 1'b0;
        wr(3'd4, 8'h00);
        @(negedge clk);
        chk("R11 irq gated", irq, 0);
        rd(3'd2); chk("R10 non-fifo rx", rdv, 8'h04);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule